// File: doc/BRIEF.md
# Sixteen-Pin Output Port with Atomic Pin Update

This block is a sixteen-pin general-purpose port that sits on a simple 32-bit memory-mapped register bus with byte-lane strobes. Software can write the whole output word, or it can raise and lower chosen pins in a single bus write, with no read-modify-write. A second, narrower register only lowers pins. Neither of these update registers stores anything: each write acts once on the output word and then is gone.

The port drives a sixteen-bit output vector and a matching per-pin output-enable vector, which comes from a direction register. The input data register shows the driven value for pins set as outputs. For pins set as inputs it shows the external pin level after a two-flop synchronizer. On every update of the output word the block pulses a per-pin change flag for one cycle on each bit that toggled.

Top module: `gpio_port`

## Requirements
- R1: When the active-low reset is low at a clock edge, the output word, direction word and change flags all become zero, and every register reads as zero.
- R2: A write to the output word at byte offset 0x00 takes effect on the clock edge that samples the write strobe. Only byte lanes 0 and 1 are stored, and bits 31:16 always read as zero.
- R3: A write to the set/clear register at offset 0x08 drives high each output whose bit is 1 in bits 15:0. It drives low each output whose bit is 1 in bits 31:16. Every other output keeps its value.
- R4: If a single write to offset 0x08 asks both to set and to clear the same pin, that pin goes high.
- R5: The set/clear register at 0x08 and the clear-only register at 0x0C always read as zero. A write to either one has no effect on any later write.
- R6: Each byte lane acts only when its strobe is set. A half-word write that strobes only lanes 1:0 of 0x08 sets pins and clears nothing. One that strobes only lanes 3:2 clears pins and sets nothing.
- R7: A write to the clear-only register at 0x0C drives low each output whose bit is 1 in bits 15:0. Bits 31:16 are ignored.
- R8: The direction register at offset 0x10 (1 = output) drives the output-enable vector, and it is written by byte lanes 1:0.
- R9: The input data register at offset 0x04 returns the output word's bit for output pins, in the same cycle as the output word changes. For input pins it returns the external pin level delayed by two clock edges.
- R10: The change flag vector is high, for exactly the one cycle after an update edge, on each bit whose output value changed at that edge. It is zero otherwise.
- R11: A write to any other offset, including an unaligned one, changes nothing, and a read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | External pin levels (asynchronous) |
| pin_out | output | 16 | Output word driving the pins |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| pin_chg | output | 16 | One-cycle pulse per output bit that toggled |

## Verification
The hardest case to reach is a stale set/clear request that corrupts a later write. It shows up only when a pin is set through one half of the set/clear register and then cleared through the other half in a separate half-word write. So the bench sets a pin through the low half, clears the same pin through the high half on its own, and checks that the pin is low. It also writes both halves in one word with the same bit in each, to confirm that the set wins. A further sequence gives the direction register a mixed value and then moves the external pins. The bench checks that output pins show the loopback value at once, while input pins take two edges to appear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    parameter int GPIO_PINS   = 16;
    parameter int BUS_DATA_W  = 32;
    parameter int BUS_ADDR_W  = 5;
    localparam int BUS_LANES  = BUS_DATA_W / 8;
    localparam int PIN_LANES  = GPIO_PINS / 8;

    localparam logic [BUS_ADDR_W-1:0] OFS_OUT  = 5'h00;
    localparam logic [BUS_ADDR_W-1:0] OFS_IN   = 5'h04;
    localparam logic [BUS_ADDR_W-1:0] OFS_SETCLR = 5'h08;
    localparam logic [BUS_ADDR_W-1:0] OFS_CLR  = 5'h0C;
    localparam logic [BUS_ADDR_W-1:0] OFS_DIR  = 5'h10;

    typedef struct packed {
        logic [GPIO_PINS-1:0] out_word;
        logic [GPIO_PINS-1:0] dir_word;
        logic [GPIO_PINS-1:0] chg;
    } port_state_t;

    function automatic logic [GPIO_PINS-1:0] lane_mask(input logic [PIN_LANES-1:0] be);
        logic [GPIO_PINS-1:0] m;
        for (int i = 0; i < PIN_LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [BUS_LANES-1:0]  bus_be,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic [GPIO_PINS-1:0]  pin_sync,
    output logic [GPIO_PINS-1:0]  out_word,
    output logic [GPIO_PINS-1:0]  dir_word,
    output logic [GPIO_PINS-1:0]  chg_flags
);
    localparam int HI = GPIO_PINS;

    port_state_t st_d, st_q;
    logic [GPIO_PINS-1:0] set_m, clr_m, lo_data_m, in_view;
    logic wr_out, wr_sc, wr_clr, wr_dir;

    assign wr_out = bus_wr && (bus_addr == OFS_OUT);
    assign wr_sc  = bus_wr && (bus_addr == OFS_SETCLR);
    assign wr_clr = bus_wr && (bus_addr == OFS_CLR);
    assign wr_dir = bus_wr && (bus_addr == OFS_DIR);

    always_comb begin
        lo_data_m = lane_mask(bus_be[PIN_LANES-1:0]);
        set_m = '0;
        clr_m = '0;
        if (wr_sc) begin
            set_m = bus_wdata[HI-1:0] & lo_data_m;
            clr_m = bus_wdata[2*HI-1:HI] & lane_mask(bus_be[2*PIN_LANES-1:PIN_LANES]);
        end else if (wr_clr) begin
            clr_m = bus_wdata[HI-1:0] & lo_data_m;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_out) begin
            st_d.out_word = (st_q.out_word & ~lo_data_m) | (bus_wdata[HI-1:0] & lo_data_m);
        end else begin
            st_d.out_word = (st_q.out_word & ~clr_m) | set_m;
        end
        if (wr_dir) begin
            st_d.dir_word = (st_q.dir_word & ~lo_data_m) | (bus_wdata[HI-1:0] & lo_data_m);
        end
        st_d.chg = st_d.out_word ^ st_q.out_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_view = (st_q.dir_word & st_q.out_word) | (~st_q.dir_word & pin_sync);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_OUT: bus_rdata[HI-1:0] = st_q.out_word;
            OFS_IN:  bus_rdata[HI-1:0] = in_view;
            OFS_DIR: bus_rdata[HI-1:0] = st_q.dir_word;
            default: bus_rdata = '0;
        endcase
    end

    assign out_word  = st_q.out_word;
    assign dir_word  = st_q.dir_word;
    assign chg_flags = st_q.chg;

    // R4
    set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sc && ((set_m & clr_m) != '0)) |=> ((out_word & $past(set_m & clr_m)) == $past(set_m & clr_m)));

    // R7
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_word & $past(clr_m)) == '0));

    // R10
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (chg_flags == (out_word ^ $past(out_word))));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(out_word) && $stable(dir_word)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] pin_in,
    output logic [15:0] pin_out,
    output logic [15:0] pin_oe,
    output logic [15:0] pin_chg
);
    logic [GPIO_PINS-1:0] pin_sync;

    gpio_sync #(.WIDTH(GPIO_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .out_word  (pin_out),
        .dir_word  (pin_oe),
        .chg_flags (pin_chg)
    );

    // R5
    update_regs_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == OFS_SETCLR) || (bus_addr == OFS_CLR)) |-> (bus_rdata == '0));

    // R2
    out_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_OUT) |-> (bus_rdata[31:16] == '0));
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = 0;
    logic [15:0] pin_out, pin_oe, pin_chg;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_out = 0;

    always #2.5 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_chg(pin_chg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drives at negedge, write lands on next posedge, returns at following negedge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_chg", pin_chg, 0);
        bus_read(5'h00, d); check("R1 out reg", d, 0);
        bus_read(5'h10, d); check("R1 dir reg", d, 0);
    endtask

    task automatic t_out_write();
        logic [31:0] d;
        bus_write(5'h00, 32'h1234_A5C3, 4'hF);
        exp_out = 16'hA5C3;
        check("R2 pin_out", pin_out, exp_out);
        check("R10 chg after out write", pin_chg, 16'hA5C3);
        bus_read(5'h00, d); check("R2 upper bits zero", d, {16'h0, exp_out});
        bus_write(5'h00, 32'hFFFF_7E00, 4'b0010);
        exp_out = 16'h7EC3;
        check("R2 byte strobe", pin_out, exp_out);
        @(negedge clk);
        check("R10 chg one cycle", pin_chg, 0);
    endtask

    task automatic t_setclr();
        bus_write(5'h08, 32'h00F0_000F, 4'hF);
        check("R3 set/clear word", pin_out, 16'h7E0F);
        check("R10 chg on set/clear", pin_chg, 16'h00CC);
        exp_out = 16'h7E0F;
        bus_write(5'h08, 32'h0101_0000, 4'hF);
        exp_out = 16'h7E0F & ~16'h0101;
        check("R3 clear only half used", pin_out, exp_out);
        bus_write(5'h08, 32'h0101_0101, 4'hF);
        exp_out = exp_out | 16'h0101;
        check("R4 set wins", pin_out, exp_out);
    endtask

    task automatic t_halves();
        logic [31:0] d;
        bus_write(5'h08, 32'hFFFF_0010, 4'b0011);
        exp_out = exp_out | 16'h0010;
        check("R6 low half sets only", pin_out, exp_out);
        bus_write(5'h08, 32'h0002_FFFF, 4'b1100);
        exp_out = exp_out & ~16'h0002;
        check("R6 high half clears only", pin_out, exp_out);
        bus_write(5'h08, 32'h0000_0020, 4'b0011);
        exp_out = exp_out | 16'h0020;
        bus_write(5'h08, 32'h0020_0000, 4'b1100);
        exp_out = exp_out & ~16'h0020;
        check("R5 no stale set", pin_out, exp_out);
        bus_read(5'h08, d); check("R5 set/clear reads zero", d, 0);
    endtask

    task automatic t_clear_only();
        logic [31:0] d;
        bus_write(5'h0C, 32'hFFFF_0003, 4'hF);
        exp_out = exp_out & ~16'h0003;
        check("R7 clear-only", pin_out, exp_out);
        bus_read(5'h0C, d); check("R5 clear-only reads zero", d, 0);
        bus_write(5'h08, 32'h0000_0001, 4'hF);
        exp_out = exp_out | 16'h0001;
        check("R5 no stale clear", pin_out, exp_out);
    endtask

    task automatic t_dir_and_input();
        logic [31:0] d;
        bus_write(5'h10, 32'hFFFF_00FF, 4'hF);
        check("R8 pin_oe", pin_oe, 16'h00FF);
        bus_read(5'h10, d); check("R8 dir reg", d, 32'h0000_00FF);
        @(negedge clk);
        pin_in = 16'hAB00;
        @(negedge clk);
        bus_read(5'h04, d); check("R9 one edge not yet", d[15:8], 8'h00);
        @(negedge clk);
        bus_read(5'h04, d); check("R9 input after two edges", d, {16'h0, 8'hAB, exp_out[7:0]});
        bus_write(5'h08, 32'h0000_0080, 4'hF);
        exp_out = exp_out | 16'h0080;
        bus_read(5'h04, d); check("R9 loopback same cycle", d[7:0], exp_out[7:0]);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(5'h14, 32'hFFFF_FFFF, 4'hF);
        check("R11 unmapped write", pin_out, exp_out);
        bus_write(5'h01, 32'hFFFF_FFFF, 4'hF);
        check("R11 unaligned write", pin_out, exp_out);
        check("R11 unaligned dir", pin_oe, 16'h00FF);
        bus_read(5'h14, d); check("R11 unmapped read", d, 0);
    endtask

    task automatic t_mid_reset();
        logic [31:0] d;
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R1 reset pin_out", pin_out, 0);
        check("R1 reset pin_oe", pin_oe, 0);
        rst_n = 1;
        bus_read(5'h00, d); check("R1 reset out reg", d, 0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        t_out_write();
        t_setclr();
        t_halves();
        t_clear_only();
        t_dir_and_input();
        t_unmapped();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule